// File: doc/BRIEF.md
# Peripheral Register Bank with Stretchable Access Phase

This block sits on the completer side of an APB link and fronts a small bank of 32-bit registers. It does not order or start transfers. It only reacts to the select, enable, address and control lines that the requester drives. In the setup cycle (select high, enable low) it decodes which register is addressed and decides whether the access is allowed. It stores that decision for the access phase that follows.

In the access phase the block holds PREADY low for a number of cycles taken from a 3-bit input. The input is sampled during setup. When the transfer completes, the block drives read data and the error flag for that single cycle and returns zero at all other times. A write changes storage only on the completing edge, and only in the byte lanes that the strobe selects. A completion may be followed at once by a new setup cycle, so back-to-back transfers need no idle cycle.

Top module: `apb_wait_regs`

## Requirements
- R1: While reset is low and in every idle cycle, pready, pslverr and prdata are 0. After reset every register reads 0.
- R2: pready is 0 in any cycle that is not an access cycle (psel=1 and penable=1). A setup cycle is one such cycle.
- R3: With a wait count of N (0 to 7) sampled in setup, pready stays 0 for the first N access cycles and rises in access cycle N+1. N=0 completes in the first access cycle.
- R4: A write to a mapped register with all four strobe bits set stores pwdata on the completing edge. A later read returns that value.
- R5: On a write, strobe bit k updates only bits 8k+7:8k of the register. Lanes whose strobe bit is 0 keep their old contents.
- R6: prdata carries the register value only in the completing cycle of an error-free read. It is 0 in every other cycle, including the wait cycles.
- R7: An address whose word index (paddr[5:2]) is not below 4 completes with pslverr=1. It changes no register, and a read of it returns prdata=0.
- R8: Register 3 (address 0x0C) is protected. A write to it with pprot[0]=0 completes with pslverr=1 and leaves it unchanged. A write with pprot[0]=1 succeeds. Reads of it are always allowed.
- R9: pslverr is 0 in every cycle other than a completing cycle.
- R10: A new setup cycle may directly follow a completing cycle. Each transfer in such a chain completes with its own data, error flag and wait count.
- R11: Changes to wait_cycles after the setup cycle do not change the length of the ongoing transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Completer selected by the requester |
| penable | input | 1 | High in the access phase, low in setup |
| paddr | input | 6 | Byte address; bits 5:2 give the word index |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte-lane write strobes |
| pprot | input | 3 | Protection attributes; bit 0 high marks a privileged access |
| wait_cycles | input | 3 | Wait states to insert, sampled in setup |
| pready | output | 1 | Access-phase completion |
| prdata | output | 32 | Read data, valid in the completing read cycle |
| pslverr | output | 1 | Error flag for the completing transfer |

## Verification
The assertions assume that the requester follows the bus protocol. Every access cycle comes directly after a setup cycle or a wait cycle. Address, direction, data and strobe stay fixed from setup until completion. Enable never rises without select. The bench has one transfer task that enforces all of this. It drives inputs only on falling edges, holds them through every wait cycle, and changes them only after a completing edge. Either a new setup or an idle cycle follows. The one signal it changes mid-transfer is wait_cycles, which the block is meant to ignore at that point.

// File: rtl/apbc_pkg.sv
// Shared widths and types for the register bank completer.
// Assumes a 32-bit data bus split into 8-bit byte lanes.
package apbc_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int STRB_W = DATA_W / LANE_W;
    localparam int WAIT_W = 3;
    localparam int PROT_W = 3;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [STRB_W-1:0] strb_t;
endpackage

// File: rtl/apbc_decode.sv
// Setup-phase decoder: maps a byte address to a word index, flags
// unmapped indices and unprivileged writes to protected registers.
// Assumes word-aligned register placement starting at address 0.
module apbc_decode #(
    parameter int ADDR_W = 6,
    parameter int NREGS = 4,
    parameter logic [NREGS-1:0] PROT_MASK = '0,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0]          paddr,
    input  logic                       pwrite,
    input  logic [apbc_pkg::PROT_W-1:0] pprot,
    output logic [IDX_W-1:0]           idx,
    output logic                       fault
);
    logic        hit;
    logic        guarded;
    logic [31:0] idx_ext;

    // Split the word index and test whether a register exists there.
    always_comb begin
        idx     = paddr[ADDR_W-1:2];
        idx_ext = 32'(idx);
        hit     = idx_ext < 32'(NREGS);
    end

    // Find out whether the addressed register is write-protected.
    always_comb begin
        guarded = 1'b0;
        for (int r = 0; r < NREGS; r++) begin
            if (idx_ext == 32'(r) && PROT_MASK[r]) guarded = 1'b1;
        end
    end

    // Combine both reasons for refusing the access.
    always_comb begin
        fault = !hit || (pwrite && guarded && !pprot[0]);
    end
endmodule

// File: rtl/apbc_wait.sv
// Wait-state generator: latches the requested count in setup and
// raises ready once that many access cycles have passed.
// Assumes access cycles follow a setup cycle without a gap.
module apbc_wait #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup,
    input  logic              access,
    input  logic [WAIT_W-1:0] wait_in,
    output logic              ready
);
    logic [WAIT_W-1:0] lim;
    logic [WAIT_W-1:0] cnt;

    // Capture the limit in setup, count stalled access cycles after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim <= '0;
            cnt <= '0;
        end else if (setup) begin
            lim <= wait_in;
            cnt <= '0;
        end else if (access && !ready) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Ready once the counted stalls reach the latched limit.
    always_comb begin
        ready = access && (cnt == lim);
    end

    // R11
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !ready) |=> $stable(lim));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access |-> (cnt <= lim));
endmodule

// File: rtl/apbc_regfile.sv
// Register storage with byte-lane write enables and one read port.
// Assumes widx and ridx are below NREGS whenever they are used.
module apbc_regfile #(
    parameter int NREGS = 4,
    parameter int IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     widx,
    input  apbc_pkg::word_t      wdata,
    input  apbc_pkg::strb_t      wstrb,
    input  logic [IDX_W-1:0]     ridx,
    output apbc_pkg::word_t      rdata
);
    import apbc_pkg::*;

    logic [NREGS-1:0][DATA_W-1:0] mem;

    // One storage lane per register and byte.
    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        for (genvar b = 0; b < STRB_W; b++) begin : g_lane
            // Update a lane only when selected, enabled and strobed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[r][b*LANE_W +: LANE_W] <= '0;
                end else if (we && (32'(widx) == 32'(r)) && wstrb[b]) begin
                    mem[r][b*LANE_W +: LANE_W] <= wdata[b*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Read selection; out-of-range indices read as zero.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NREGS; r++) begin
            if (32'(ridx) == 32'(r)) rdata = mem[r];
        end
    end

    // R7 R8
    hold_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem));
endmodule

// File: rtl/apb_wait_regs.sv
// APB completer in front of a register bank: decodes in setup,
// stretches access by a sampled wait count, drives read data and
// error only in the completing cycle. Assumes a protocol-correct
// requester that holds address and control stable until completion.
module apb_wait_regs #(
    parameter int ADDR_W = 6,
    parameter int NREGS = 4,
    parameter logic [NREGS-1:0] PROT_MASK = 4'b1000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         psel,
    input  logic                         penable,
    input  logic [ADDR_W-1:0]            paddr,
    input  logic                         pwrite,
    input  logic [apbc_pkg::DATA_W-1:0]  pwdata,
    input  logic [apbc_pkg::STRB_W-1:0]  pstrb,
    input  logic [apbc_pkg::PROT_W-1:0]  pprot,
    input  logic [apbc_pkg::WAIT_W-1:0]  wait_cycles,
    output logic                         pready,
    output logic [apbc_pkg::DATA_W-1:0]  prdata,
    output logic                         pslverr
);
    import apbc_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic             setup_ph;
    logic             access_ph;
    logic             rdy;
    logic             done;
    logic             we;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_fault;
    logic [IDX_W-1:0] idx_q;
    logic             fault_q;
    word_t            rd;

    // Classify the current bus cycle.
    always_comb begin
        setup_ph  = psel && !penable;
        access_ph = psel && penable;
    end

    apbc_decode #(
        .ADDR_W(ADDR_W), .NREGS(NREGS), .PROT_MASK(PROT_MASK)
    ) u_dec (
        .paddr(paddr), .pwrite(pwrite), .pprot(pprot),
        .idx(dec_idx), .fault(dec_fault)
    );

    // Keep the setup-phase decision for the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            fault_q <= 1'b0;
        end else if (setup_ph) begin
            idx_q   <= dec_idx;
            fault_q <= dec_fault;
        end
    end

    apbc_wait #(.WAIT_W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .setup(setup_ph), .access(access_ph),
        .wait_in(wait_cycles), .ready(rdy)
    );

    // Completion and the write enable that depends on it.
    always_comb begin
        done = access_ph && rdy;
        we   = done && pwrite && !fault_q;
    end

    apbc_regfile #(.NREGS(NREGS), .IDX_W(IDX_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .widx(idx_q),
        .wdata(pwdata), .wstrb(pstrb), .ridx(idx_q), .rdata(rd)
    );

    // Outputs are gated to the completing cycle.
    always_comb begin
        pready  = rdy;
        pslverr = done && fault_q;
        prdata  = (done && !pwrite && !fault_q) ? rd : '0;
    end

    // R2
    no_ready_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |-> !pready);

    // R9
    err_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable && pready));

    // R6
    rdata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prdata != '0) |-> (pready && !pwrite && !pslverr));

    // R3
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((psel && !penable && wait_cycles == '0) ##1 (psel && penable)) |-> pready);
endmodule

// File: tb/sim_apb_wait_regs.sv
`timescale 1ns/100ps
module sim_apb_wait_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic [5:0]  paddr = '0;
    logic        pwrite = 1'b0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [2:0]  pprot = '0;
    logic [2:0]  wait_cycles = '0;
    logic        pready;
    logic [31:0] prdata;
    logic        pslverr;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [0:3];

    always #2.5 clk = ~clk;

    apb_wait_regs u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .pstrb(pstrb),
        .pprot(pprot), .wait_cycles(wait_cycles), .pready(pready),
        .prdata(prdata), .pslverr(pslverr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One transfer: setup, then access until pready; returns results.
    task automatic xfer(input logic wr, input logic [5:0] a, input logic [31:0] wd,
                        input logic [3:0] st, input logic [2:0] pr, input logic [2:0] wc,
                        output logic [31:0] rd, output logic er, output int n);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; paddr = a; pwrite = wr;
        pwdata = wd; pstrb = st; pprot = pr; wait_cycles = wc;
        #1 chk("R2 setup pready", {31'b0, pready}, 32'd0);
        @(negedge clk);
        penable = 1'b1;
        wait_cycles = ~wc;
        n = 0;
        forever begin
            #1;
            if (pready) break;
            if (pslverr !== 1'b0 || prdata !== 32'd0)
                chk("R6 R9 wait outputs", {31'b0, pslverr} | prdata, 32'd0);
            n++;
            if (n > 20) begin
                chk("R3 no ready", 32'(n), 32'(wc));
                break;
            end
            @(negedge clk);
        end
        rd = prdata;
        er = pslverr;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1 chk("R1 idle outputs", {30'b0, pready, pslverr} | prdata, 32'd0);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] wd, input logic [3:0] st,
                            input logic [2:0] pr, input logic [2:0] wc, input logic exp_err);
        logic [31:0] rd; logic er; int n;
        xfer(1'b1, a, wd, st, pr, wc, rd, er, n);
        chk("R3 R11 write wait count", 32'(n), 32'(wc));
        chk("R7 R8 write error flag", {31'b0, er}, {31'b0, exp_err});
        if (!exp_err)
            for (int b = 0; b < 4; b++)
                if (st[b]) model[a[3:2]][b*8 +: 8] = wd[b*8 +: 8];
    endtask

    task automatic do_read(input string req, input logic [5:0] a, input logic [2:0] wc,
                           input logic exp_err);
        logic [31:0] rd; logic er; int n;
        logic [31:0] exp;
        xfer(1'b0, a, 32'hDEAD_BEEF, 4'h0, 3'b000, wc, rd, er, n);
        exp = exp_err ? 32'd0 : model[a[3:2]];
        chk({req, " read data"}, rd, exp);
        chk({req, " read error"}, {31'b0, er}, {31'b0, exp_err});
        chk("R3 R11 read wait count", 32'(n), 32'(wc));
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", {30'b0, pready, pslverr} | prdata, 32'd0);
        for (int r = 0; r < 4; r++) begin
            do_read("R1 reset value", 6'(r * 4), 3'd0, 1'b0);
            idle_cycle();
        end
    endtask

    task automatic t_basic();
        for (int r = 0; r < 4; r++) begin
            do_write(6'(r * 4), 32'h1111_0000 * (r + 1) + 32'h55, 4'hF, 3'b001, 3'd0, 1'b0);
            idle_cycle();
        end
        for (int r = 0; r < 4; r++) begin
            do_read("R4 R6 full write", 6'(r * 4), 3'd1, 1'b0);
            idle_cycle();
        end
    endtask

    task automatic t_strobe();
        do_write(6'h04, 32'hA1B2_C3D4, 4'b0101, 3'b000, 3'd2, 1'b0);
        idle_cycle();
        do_read("R5 strobe 0101", 6'h04, 3'd0, 1'b0);
        idle_cycle();
        do_write(6'h04, 32'h0F0F_0F0F, 4'b1000, 3'b000, 3'd0, 1'b0);
        idle_cycle();
        do_read("R5 strobe 1000", 6'h04, 3'd0, 1'b0);
        idle_cycle();
    endtask

    task automatic t_waits();
        for (int w = 0; w < 8; w++) begin
            do_write(6'h08, 32'hC0DE_0000 + 32'(w), 4'hF, 3'b000, 3'(w), 1'b0);
            idle_cycle();
            do_read("R3 wait sweep", 6'h08, 3'(7 - w), 1'b0);
            idle_cycle();
        end
    endtask

    task automatic t_unmapped();
        do_write(6'h20, 32'hFFFF_FFFF, 4'hF, 3'b001, 3'd1, 1'b1);
        idle_cycle();
        do_read("R7 unmapped", 6'h3C, 3'd2, 1'b1);
        idle_cycle();
        for (int r = 0; r < 4; r++) begin
            do_read("R7 unchanged", 6'(r * 4), 3'd0, 1'b0);
            idle_cycle();
        end
    endtask

    task automatic t_protect();
        do_write(6'h0C, 32'h1234_5678, 4'hF, 3'b000, 3'd1, 1'b1);
        idle_cycle();
        do_read("R8 denied write", 6'h0C, 3'd0, 1'b0);
        idle_cycle();
        do_write(6'h0C, 32'h1234_5678, 4'hF, 3'b001, 3'd0, 1'b0);
        idle_cycle();
        do_read("R8 privileged write", 6'h0C, 3'd3, 1'b0);
        idle_cycle();
    endtask

    task automatic t_b2b();
        do_write(6'h00, 32'hBEEF_0001, 4'hF, 3'b000, 3'd0, 1'b0);
        do_read("R10 chain read 1", 6'h00, 3'd0, 1'b0);
        do_write(6'h30, 32'h0, 4'hF, 3'b000, 3'd2, 1'b1);
        do_write(6'h04, 32'hBEEF_0002, 4'h3, 3'b000, 3'd1, 1'b0);
        do_read("R10 chain read 2", 6'h04, 3'd0, 1'b0);
        do_read("R10 chain bad", 6'h10, 3'd0, 1'b1);
        idle_cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < 4; r++) model[r] = 32'd0;
        repeat (3) @(posedge clk);
        #1 chk("R1 outputs in reset", {30'b0, pready, pslverr} | prdata, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_strobe();
        t_waits();
        t_unmapped();
        t_protect();
        t_b2b();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule